// File: doc/BRIEF.md
# Transceiver Mode Control Register and MII Effects

This block holds one vendor-defined management register of a 10/100 Ethernet transceiver and applies its control bits to the MII-facing signals. Software writes the register over a simple parallel bus (address, write strobe, data) and reads it back combinationally. The stored bits select repeater operation, the polarity of the interrupt pin, a high-impedance request for the transmit side, inhibition of the post-transmit collision test pulse, and a natural loopback of transmit nibbles onto the receive nibble bus while the 10 Mb/s mode is active.

From these bits and the live MII inputs the block derives carrier sense, the effective duplex, the COL output (including the 10 Mb/s heartbeat pulse that follows each transmitted frame), the level-adjusted interrupt pin, a drive enable for the transmit line outputs and transmit clock, and the registered receive nibble path. The reset input is asynchronous and active low; its release is synchronised inside the block, so internal state leaves reset two clock edges after the pin rises.

Top module: `phy_mode_ctrl`

## Requirements
- R1: After reset, a read at the register address (default 16) returns 16'h0140; a read at any other address returns 0.
- R2: A write at the register address stores only bits 15, 14, 12, 11, 10, 9:6, 5 and 4; bit 13 and bits 3:0 always read 0, and a write at another address changes nothing.
- R3: While bit 15 (repeater) is 1, full_dup is 0 whatever dup_req is; while it is 0, full_dup equals dup_req.
- R4: With bit 15 set, crs equals rx_act; with bit 15 clear, crs is rx_act OR tx_en in half duplex and rx_act alone in full duplex.
- R5: With bit 14 at 0 the intr pin is the inverse of irq_req (low means pending); with bit 14 at 1 it equals irq_req.
- R6: tx_drv_en is 0 exactly while bit 12 is 1, and the receive nibble path still delivers rxd_in while it is set.
- R7: With is_10m=1, bit 11=0 and bit 15=0, the first clock edge that samples tx_en low after it was high starts the test pulse: counting that edge as 0, the internal pulse is high after edges 8 through 17 (10 cycles) and low otherwise.
- R8: No test pulse is produced when, at the falling edge of tx_en, bit 11 is 1, bit 15 is 1, or is_10m is 0.
- R9: rxd and rx_dv are registered one cycle; when bit 10 is 1 and is_10m is 1 they carry txd and tx_en, otherwise rxd_in and rx_dv_in.
- R10: col is the OR of col_line and the test pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register bus address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on reg_addr |
| is_10m | input | 1 | 1 when the 10 Mb/s mode is active |
| dup_req | input | 1 | Requested full duplex |
| irq_req | input | 1 | Internal interrupt request, active high |
| tx_en | input | 1 | MII transmit enable |
| txd | input | 4 | MII transmit nibble |
| rx_act | input | 1 | Receive activity from the line side |
| rxd_in | input | 4 | Received nibble from the line side |
| rx_dv_in | input | 1 | Received data valid from the line side |
| col_line | input | 1 | Collision detected on the line |
| crs | output | 1 | MII carrier sense |
| col | output | 1 | MII collision |
| full_dup | output | 1 | Effective full-duplex state |
| intr | output | 1 | Interrupt pin, polarity per bit 14 |
| tx_drv_en | output | 1 | Enable for transmit line outputs and transmit clock |
| rxd | output | 4 | MII receive nibble, registered |
| rx_dv | output | 1 | MII receive data valid, registered |

## Verification
Register reads, crs, full_dup, intr, tx_drv_en and col_line passthrough are combinational, so the bench changes inputs at the falling clock edge and samples a nanosecond later, while register writes take effect after the next rising edge. The receive nibble path lags its source by exactly one rising edge, so its checks drive at one falling edge and sample at the following one. The test pulse is checked cycle by cycle: the bench lowers tx_en at a falling edge, takes the next rising edge as edge 0, and compares col at every following falling edge against the window of edges 8 to 17 for an enabled pulse and against constant 0 for every suppressing condition.

// File: rtl/phy_mode_pkg.sv
package phy_mode_pkg;
  localparam int REG_W  = 16;
  localparam int B_RPT  = 15;
  localparam int B_IPOL = 14;
  localparam int B_TXHZ = 12;
  localparam int B_SQEI = 11;
  localparam int B_NLB  = 10;
  localparam logic [REG_W-1:0] RST_VAL = 16'h0140;
  localparam logic [REG_W-1:0] WR_MASK = 16'hDFF0;

  typedef struct packed {
    logic rpt;
    logic ipol;
    logic txhz;
    logic sqe_inh;
    logic nat_lb;
  } mode_ctl_t;
endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pmc_mode_reg.sv
module pmc_mode_reg
  import phy_mode_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int REG_ADDR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output mode_ctl_t         ctl
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

  logic [REG_W-1:0] val_q, val_nxt;
  logic             hit, wr_en;

  assign hit   = (addr == MY_ADDR);
  assign wr_en = we & hit;

  always_comb begin
    val_nxt = (wdata & WR_MASK) | (val_q & ~WR_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     val_q <= RST_VAL;
    else if (wr_en) val_q <= val_nxt;
  end

  always_comb begin
    rdata = hit ? (val_q & WR_MASK) : '0;
  end

  assign ctl.rpt     = val_q[B_RPT];
  assign ctl.ipol    = val_q[B_IPOL];
  assign ctl.txhz    = val_q[B_TXHZ];
  assign ctl.sqe_inh = val_q[B_SQEI];
  assign ctl.nat_lb  = val_q[B_NLB];

  // R2: a write elsewhere leaves the register untouched
  p_no_stray_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !hit) |=> $stable(val_q));

  // R2: fixed-zero bits never become set
  p_fixed_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (val_q & ~WR_MASK) == '0);
endmodule

// File: rtl/pmc_sqe_gen.sv
module pmc_sqe_gen #(
  parameter int SQE_DELAY = 8,
  parameter int SQE_WIDTH = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic arm,
  output logic pulse
);
  localparam int LAST = SQE_DELAY + SQE_WIDTH - 1;
  localparam int CW   = $clog2(LAST + 2);
  localparam int RW   = $clog2(SQE_WIDTH + 2);
  localparam logic [CW-1:0] C_DLY  = CW'(SQE_DELAY);
  localparam logic [CW-1:0] C_LAST = CW'(LAST);
  localparam logic [RW-1:0] R_MAX  = RW'(SQE_WIDTH);

  logic          tx_q;
  logic          busy_q, busy_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          fall, step;

  assign fall = tx_q & ~tx_en;
  assign step = busy_q | (fall & arm);

  always_comb begin
    busy_nxt = busy_q;
    cnt_nxt  = cnt_q;
    if (fall && arm) begin
      busy_nxt = 1'b1;
      cnt_nxt  = '0;
    end else if (busy_q) begin
      if (cnt_q == C_LAST) begin
        busy_nxt = 1'b0;
        cnt_nxt  = '0;
      end else begin
        cnt_nxt  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= 1'b0;
    else        tx_q <= tx_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (step) begin
      busy_q <= busy_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

  assign pulse = busy_q & (cnt_q >= C_DLY);

  // checker: length of the current pulse run
  logic [RW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_q <= '0;
    else if (pulse) run_q <= (run_q == R_MAX) ? run_q : run_q + 1'b1;
    else            run_q <= '0;
  end

  // R7: a pulse never lasts longer than its configured width
  p_sqe_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (run_q < R_MAX));

  // R8: an unarmed fall with nothing running starts no pulse
  p_sqe_unarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !arm && !busy_q) |=> !pulse);
endmodule

// File: rtl/pmc_mii_ctl.sv
module pmc_mii_ctl
  import phy_mode_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_ctl_t        ctl,
  input  logic             is_10m,
  input  logic             dup_req,
  input  logic             irq_req,
  input  logic             tx_en,
  input  logic [NIB_W-1:0] txd,
  input  logic             rx_act,
  input  logic [NIB_W-1:0] rxd_in,
  input  logic             rx_dv_in,
  input  logic             col_line,
  input  logic             sqe,
  output logic             crs,
  output logic             col,
  output logic             full_dup,
  output logic             intr,
  output logic             tx_drv_en,
  output logic [NIB_W-1:0] rxd,
  output logic             rx_dv
);
  logic             lb_en;
  logic [NIB_W-1:0] rxd_nxt, rxd_q;
  logic             dv_nxt, dv_q;

  always_comb begin
    full_dup = dup_req & ~ctl.rpt;
    if (ctl.rpt)       crs = rx_act;
    else if (full_dup) crs = rx_act;
    else               crs = rx_act | tx_en;
    intr      = ctl.ipol ? irq_req : ~irq_req;
    tx_drv_en = ~ctl.txhz;
    col       = col_line | sqe;
  end

  assign lb_en = ctl.nat_lb & is_10m;

  always_comb begin
    rxd_nxt = lb_en ? txd   : rxd_in;
    dv_nxt  = lb_en ? tx_en : rx_dv_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_q <= '0;
      dv_q  <= 1'b0;
    end else begin
      rxd_q <= rxd_nxt;
      dv_q  <= dv_nxt;
    end
  end

  assign rxd   = rxd_q;
  assign rx_dv = dv_q;

  // R3: repeater mode never reports full duplex
  p_fdx_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.rpt |-> !full_dup);

  // R4: in repeater mode own transmission does not raise carrier
  p_crs_rpt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.rpt && !rx_act) |-> !crs);

  // R5: a pending request drives the pin to the configured level
  p_intr_pol_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (intr == ctl.ipol));

  // R9: loopback data appears one edge later, aligned with valid
  p_lb_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lb_en) |-> (rxd == $past(txd) && rx_dv == $past(tx_en)));

  // R10: the test pulse always reaches COL
  p_col_sqe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sqe |-> col);
endmodule

// File: rtl/phy_mode_ctrl.sv
module phy_mode_ctrl
  import phy_mode_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int REG_ADDR  = 16,
  parameter int NIB_W     = 4,
  parameter int SQE_DELAY = 8,
  parameter int SQE_WIDTH = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              is_10m,
  input  logic              dup_req,
  input  logic              irq_req,
  input  logic              tx_en,
  input  logic [NIB_W-1:0]  txd,
  input  logic              rx_act,
  input  logic [NIB_W-1:0]  rxd_in,
  input  logic              rx_dv_in,
  input  logic              col_line,
  output logic              crs,
  output logic              col,
  output logic              full_dup,
  output logic              intr,
  output logic              tx_drv_en,
  output logic [NIB_W-1:0]  rxd,
  output logic              rx_dv
);
  logic      rst_ni;
  mode_ctl_t ctl;
  logic      sqe_arm, sqe;

  pmc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ni)
  );

  pmc_mode_reg #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
  ) u_reg (
    .clk   (clk),
    .rst_n (rst_ni),
    .addr  (reg_addr),
    .we    (reg_we),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .ctl   (ctl)
  );

  assign sqe_arm = is_10m & ~ctl.sqe_inh & ~ctl.rpt;

  pmc_sqe_gen #(
    .SQE_DELAY (SQE_DELAY),
    .SQE_WIDTH (SQE_WIDTH)
  ) u_sqe (
    .clk   (clk),
    .rst_n (rst_ni),
    .tx_en (tx_en),
    .arm   (sqe_arm),
    .pulse (sqe)
  );

  pmc_mii_ctl #(
    .NIB_W (NIB_W)
  ) u_mii (
    .clk       (clk),
    .rst_n     (rst_ni),
    .ctl       (ctl),
    .is_10m    (is_10m),
    .dup_req   (dup_req),
    .irq_req   (irq_req),
    .tx_en     (tx_en),
    .txd       (txd),
    .rx_act    (rx_act),
    .rxd_in    (rxd_in),
    .rx_dv_in  (rx_dv_in),
    .col_line  (col_line),
    .sqe       (sqe),
    .crs       (crs),
    .col       (col),
    .full_dup  (full_dup),
    .intr      (intr),
    .tx_drv_en (tx_drv_en),
    .rxd       (rxd),
    .rx_dv     (rx_dv)
  );
endmodule

// File: tb/tb_phy_mode_ctrl.sv
`timescale 1ns/1ps
module tb_phy_mode_ctrl;
  localparam int DLY = 8;
  localparam int WID = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  reg_addr;
  logic        reg_we;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        is_10m, dup_req, irq_req, tx_en, rx_act, rx_dv_in, col_line;
  logic [3:0]  txd, rxd_in, rxd;
  logic        crs, col, full_dup, intr, tx_drv_en, rx_dv;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  phy_mode_ctrl #(.SQE_DELAY(DLY), .SQE_WIDTH(WID)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .is_10m(is_10m),
    .dup_req(dup_req), .irq_req(irq_req), .tx_en(tx_en), .txd(txd),
    .rx_act(rx_act), .rxd_in(rxd_in), .rx_dv_in(rx_dv_in),
    .col_line(col_line), .crs(crs), .col(col), .full_dup(full_dup),
    .intr(intr), .tx_drv_en(tx_drv_en), .rxd(rxd), .rx_dv(rx_dv)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 5'd16;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 5'd16;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(5'd16, d); chk("R1 reset value", d, 16'h0140);
    rd(5'd3, d);  chk("R1 other address", d, 16'h0000);
    chk("R5 idle pin high", intr, 1'b1);
    chk("R6 drive enabled", tx_drv_en, 1'b1);
    chk("R10 col idle", col, 1'b0);
  endtask

  task automatic t_regs;
    logic [15:0] d;
    wr(5'd16, 16'hFFFF); rd(5'd16, d); chk("R2 write mask", d, 16'hDFF0);
    wr(5'd16, 16'h0000); rd(5'd16, d); chk("R2 clear", d, 16'h0000);
    wr(5'd17, 16'hFFFF); rd(5'd16, d); chk("R2 stray write", d, 16'h0000);
    wr(5'd16, 16'h0140);
  endtask

  task automatic t_duplex;
    @(negedge clk); dup_req = 1'b1; #1 chk("R3 no repeater", full_dup, 1'b1);
    wr(5'd16, 16'h8140);
    #1 chk("R3 repeater blocks", full_dup, 1'b0);
    wr(5'd16, 16'h0140);
    dup_req = 1'b0;
  endtask

  task automatic t_crs;
    @(negedge clk); tx_en = 1'b1; rx_act = 1'b0; dup_req = 1'b0;
    #1 chk("R4 half duplex tx", crs, 1'b1);
    dup_req = 1'b1; #1 chk("R4 full duplex tx", crs, 1'b0);
    rx_act = 1'b1;  #1 chk("R4 full duplex rx", crs, 1'b1);
    dup_req = 1'b0; rx_act = 1'b0;
    wr(5'd16, 16'h8940);
    #1 chk("R4 repeater tx", crs, 1'b0);
    rx_act = 1'b1; #1 chk("R4 repeater rx", crs, 1'b1);
    @(negedge clk); tx_en = 1'b0; rx_act = 1'b0;
    wr(5'd16, 16'h0140);
  endtask

  task automatic t_intr;
    @(negedge clk); irq_req = 1'b1; #1 chk("R5 active low", intr, 1'b0);
    wr(5'd16, 16'h4140);
    #1 chk("R5 active high", intr, 1'b1);
    irq_req = 1'b0; #1 chk("R5 high idle", intr, 1'b0);
    wr(5'd16, 16'h0140);
  endtask

  task automatic t_txhz;
    wr(5'd16, 16'h1140);
    #1 chk("R6 drive off", tx_drv_en, 1'b0);
    @(negedge clk); rxd_in = 4'h9; rx_dv_in = 1'b1;
    @(negedge clk);
    chk("R6 rx data", rxd, 4'h9); chk("R6 rx valid", rx_dv, 1'b1);
    rx_dv_in = 1'b0;
    wr(5'd16, 16'h0140);
  endtask

  task automatic sqe_run(input string req, input logic exp_on);
    int miss = 0;
    int highs = 0;
    @(negedge clk); tx_en = 1'b1;
    repeat (3) @(negedge clk);
    tx_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    if (col !== 1'b0) miss++;
    for (int k = 1; k <= DLY + WID + 3; k++) begin
      @(negedge clk);
      if (col === 1'b1) highs++;
      if (col !== (exp_on && k >= DLY && k < DLY + WID)) miss++;
    end
    chk(req, miss, 0);
    chk(req, highs, exp_on ? WID : 0);
  endtask

  task automatic t_sqe_on;
    is_10m = 1'b1;
    sqe_run("R7 pulse window", 1'b1);
  endtask

  task automatic t_sqe_off;
    wr(5'd16, 16'h0940); sqe_run("R8 inhibit", 1'b0);
    wr(5'd16, 16'h8140); sqe_run("R8 repeater", 1'b0);
    wr(5'd16, 16'h0140);
    is_10m = 1'b0; sqe_run("R8 100M", 1'b0);
    is_10m = 1'b1;
  endtask

  task automatic t_loop;
    wr(5'd16, 16'h0540);
    @(negedge clk); txd = 4'hA; tx_en = 1'b1; rxd_in = 4'h5; rx_dv_in = 1'b0;
    @(negedge clk);
    chk("R9 loop data", rxd, 4'hA); chk("R9 loop valid", rx_dv, 1'b1);
    is_10m = 1'b0;
    @(negedge clk);
    chk("R9 100M data", rxd, 4'h5); chk("R9 100M valid", rx_dv, 1'b0);
    is_10m = 1'b1; tx_en = 1'b0;
    wr(5'd16, 16'h0140);
    @(negedge clk);
    chk("R9 off data", rxd, 4'h5);
  endtask

  task automatic t_col;
    @(negedge clk); col_line = 1'b1; #1 chk("R10 line col", col, 1'b1);
    col_line = 1'b0; #1 chk("R10 line col clear", col, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; reg_addr = 5'd16; reg_we = 1'b0; reg_wdata = '0;
    is_10m = 1'b1; dup_req = 1'b0; irq_req = 1'b0; tx_en = 1'b0; txd = '0;
    rx_act = 1'b0; rxd_in = '0; rx_dv_in = 1'b0; col_line = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset; t_regs; t_duplex; t_crs; t_intr; t_txhz;
    t_sqe_on; t_sqe_off; t_loop; t_col;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule